// File: doc/BRIEF.md
# Calendar Alarm Comparator with Latched Interrupt

This block watches a running BCD calendar, which another block counts and presents on a single bus, and compares it with an alarm time held in its own registers. Software writes each alarm field into a staging register together with a flag that says whether the field takes part in the comparison. The staged set reaches the comparator only when a commit write is made. This lets a complete alarm be written one field at a time without ever matching against a half-written time.

The comparison runs only in the cycle where the calendar raises its once-per-second tick. If at least one field takes part and every participating field is equal, a sticky status bit is set. The status bit is set whether or not the interrupt is enabled. The interrupt line is the status bit gated by a separate enable bit. Software clears the status bit by writing a one to it.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset the status bit, the interrupt line, the interrupt enable and every field's participation flag are 0. A tick after reset therefore sets nothing.
- R2: The alarm field registers sit at these write addresses: 0 seconds (7 bits), 1 minutes (7 bits), 2 hours (6 bits), 3 weekday (3 bits), 4 day (6 bits), 5 month (5 bits), 6 year (8 bits). Each value is held in the low bits of the write data and bit 15 is the field's participation flag. The calendar bus packs the same fields from bit 0 upward in that order, giving 42 bits.
- R3: Writes to addresses 0 to 6 do not change the comparison. Only a write to address 7 with bit 15 set copies all staged fields and flags into the active set. A write to address 7 with bit 15 clear has no effect.
- R4: In a tick cycle, if any field participates and all participating fields equal their calendar fields, the status bit reads 1 from the next cycle. Non-participating fields, for example the weekday, are ignored.
- R5: A match is evaluated only in a tick cycle. A calendar that stays equal between ticks does not set the status bit again after it has been cleared.
- R6: When no field participates, the status bit is never set.
- R7: Bit 0 at address 8 is the interrupt enable. The status bit latches whatever the enable is, and the interrupt line equals status AND enable.
- R8: Writing address 9 with bit 0 set clears the status bit. Writing address 9 with bit 0 clear leaves it unchanged.
- R9: When a match and a clear write fall in the same cycle, the status bit stays set.
- R10: A difference in any single participating field, including the year, prevents the status bit from being set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle strobe when the calendar advances by one second |
| cal_i | input | 42 | Current BCD calendar, fields packed as in R2 |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| alarm_sts_o | output | 1 | Latched alarm status bit |
| alarm_irq_o | output | 1 | Interrupt line, status gated by enable |

## Verification
A detected match and a software clear of the status bit can land in the same clock cycle. The bench provokes this by presenting a matching calendar with the tick while it writes a one to the status address in that same cycle. The status bit must read 1 afterwards, because the set takes priority over the clear. A following clear write without a tick must then bring it to 0, which shows that the earlier write was overridden rather than ignored.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;

  localparam int NUM_FIELDS = 7;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 4;
  localparam int FLAG_BIT   = 15;

  // BCD width of each field, seconds first
  function automatic int field_w(input int idx);
    case (idx)
      0:       return 7;
      1:       return 7;
      2:       return 6;
      3:       return 3;
      4:       return 6;
      5:       return 5;
      default: return 8;
    endcase
  endfunction

  function automatic int field_lsb(input int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += field_w(k);
    return acc;
  endfunction

  localparam int CAL_W = field_lsb(NUM_FIELDS);

  localparam logic [ADDR_W-1:0] ADR_COMMIT = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 4'd8;
  localparam logic [ADDR_W-1:0] ADR_ISTS   = 4'd9;

endpackage

// File: rtl/cal_alarm_stage.sv
module cal_alarm_stage
  import cal_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [REG_W-1:0]      wr_data_i,
  output logic [CAL_W-1:0]      act_val_o,
  output logic [NUM_FIELDS-1:0] act_en_o
);

  logic commit;
  logic unused_hi_bits;

  assign commit         = wr_en_i && (wr_addr_i == ADR_COMMIT) && wr_data_i[FLAG_BIT];
  assign unused_hi_bits = ^wr_data_i[FLAG_BIT-1:8];

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam int W = field_w(g);
    localparam int L = field_lsb(g);
    localparam logic [ADDR_W-1:0] MY_ADR = ADDR_W'(g);

    logic [W-1:0] stg_val_q, stg_val_d, act_val_q, act_val_d;
    logic         stg_flg_q, stg_flg_d, act_flg_q, act_flg_d;
    logic         stg_ld, act_ld;

    always_comb begin
      stg_ld    = wr_en_i && (wr_addr_i == MY_ADR);
      stg_val_d = wr_data_i[W-1:0];
      stg_flg_d = wr_data_i[FLAG_BIT];
      act_ld    = commit;
      act_val_d = stg_val_q;
      act_flg_d = stg_flg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_val_q <= '0;
        stg_flg_q <= 1'b0;
      end else if (stg_ld) begin
        stg_val_q <= stg_val_d;
        stg_flg_q <= stg_flg_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_val_q <= '0;
        act_flg_q <= 1'b0;
      end else if (act_ld) begin
        act_val_q <= act_val_d;
        act_flg_q <= act_flg_d;
      end
    end

    assign act_val_o[L +: W] = act_val_q;
    assign act_en_o[g]       = act_flg_q;
  end

endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic                  tick_i,
  input  logic [CAL_W-1:0]      cal_i,
  input  logic [CAL_W-1:0]      act_val_i,
  input  logic [NUM_FIELDS-1:0] act_en_i,
  output logic                  match_o
);

  logic [NUM_FIELDS-1:0] field_ok;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_eq
    localparam int W = field_w(g);
    localparam int L = field_lsb(g);
    assign field_ok[g] = !act_en_i[g] || (cal_i[L +: W] == act_val_i[L +: W]);
  end

  assign match_o = tick_i && (|act_en_i) && (&field_ok);

endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq
  import cal_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_bit0_i,
  input  logic              match_i,
  output logic              sts_o,
  output logic              ien_o,
  output logic              irq_o
);

  logic sts_q, sts_d, sts_ld;
  logic ien_q, ien_d, ien_ld;
  logic clr_req;

  always_comb begin
    clr_req = wr_en_i && (wr_addr_i == ADR_ISTS) && wr_bit0_i;
    sts_ld  = match_i || clr_req;
    sts_d   = match_i;
    ien_ld  = wr_en_i && (wr_addr_i == ADR_IEN);
    ien_d   = wr_bit0_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= 1'b0;
    else if (sts_ld) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ien_q <= 1'b0;
    else if (ien_ld) ien_q <= ien_d;
  end

  assign sts_o = sts_q;
  assign ien_o = ien_q;
  assign irq_o = sts_q && ien_q;

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CAL_W-1:0] cal_i,
  input  logic             wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic             alarm_sts_o,
  output logic             alarm_irq_o
);

  logic                  rst_meta_q, rst_sync_n;
  logic [CAL_W-1:0]      act_val_w;
  logic [NUM_FIELDS-1:0] act_en_w;
  logic                  match_w;
  logic                  ien_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cal_alarm_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .act_val_o (act_val_w),
    .act_en_o  (act_en_w)
  );

  cal_alarm_cmp u_cmp (
    .tick_i    (tick_i),
    .cal_i     (cal_i),
    .act_val_i (act_val_w),
    .act_en_i  (act_en_w),
    .match_o   (match_w)
  );

  cal_alarm_irq u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_bit0_i (wr_data_i[0]),
    .match_i   (match_w),
    .sts_o     (alarm_sts_o),
    .ien_o     (ien_w),
    .irq_o     (alarm_irq_o)
  );

endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_alarm_pkg::*;
(
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic                  tick_i,
  input logic                  wr_en_i,
  input logic [ADDR_W-1:0]     wr_addr_i,
  input logic [REG_W-1:0]      wr_data_i,
  input logic                  match_w,
  input logic [NUM_FIELDS-1:0] act_en_w,
  input logic                  alarm_sts_o,
  input logic                  alarm_irq_o
);

  // R7
  irq_needs_sts_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    alarm_irq_o |-> alarm_sts_o);

  // R5
  set_only_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(alarm_sts_o) |-> $past(tick_i));

  // R8
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en_i && wr_addr_i == ADR_ISTS && wr_data_i[0] && !match_w) |=> !alarm_sts_o);

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    match_w |=> alarm_sts_o);

  // R6
  no_field_no_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (act_en_w == '0 && !alarm_sts_o) |=> !alarm_sts_o);

  // R3
  commit_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(wr_en_i && wr_addr_i == ADR_COMMIT && wr_data_i[FLAG_BIT]) |=> $stable(act_en_w));

endmodule

bind cal_alarm_match cal_alarm_chk chk_i (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .tick_i      (tick_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_data_i   (wr_data_i),
  .match_w     (match_w),
  .act_en_w    (act_en_w),
  .alarm_sts_o (alarm_sts_o),
  .alarm_irq_o (alarm_irq_o)
);

// File: tb/cal_alarm_match_tb_top.sv
module cal_alarm_match_tb_top;

  logic        clk;
  logic        rst_n;
  logic        tick_i;
  logic [41:0] cal_i;
  logic        wr_en_i;
  logic [3:0]  wr_addr_i;
  logic [15:0] wr_data_i;
  logic        alarm_sts_o;
  logic        alarm_irq_o;

  int n_tests;
  int n_fail;
  bit done;

  bit    q_sts[$];
  bit    q_irq[$];
  string q_tag[$];

  cal_alarm_match dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_i),
    .cal_i       (cal_i),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .alarm_sts_o (alarm_sts_o),
    .alarm_irq_o (alarm_irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [41:0] pack_cal(input logic [6:0] s, input logic [6:0] m,
                                           input logic [5:0] h, input logic [2:0] w,
                                           input logic [5:0] d, input logic [4:0] mo,
                                           input logic [7:0] y);
    return {y, mo, d, w, h, m, s};
  endfunction

  // monitor: pops expected items and compares
  always @(negedge clk) begin
    if (q_tag.size() > 0) begin
      bit    es;
      bit    ei;
      string t;
      es = q_sts.pop_front();
      ei = q_irq.pop_front();
      t  = q_tag.pop_front();
      n_tests++;
      if (alarm_sts_o !== es || alarm_irq_o !== ei) begin
        n_fail++;
        $display("FAIL %s: sts/irq got %b/%b expected %b/%b", t, alarm_sts_o, alarm_irq_o, es, ei);
      end
    end
  end

  // driver: one cycle of stimulus, then queues the expected outputs
  task automatic step(input bit tk, input logic [41:0] cv, input bit we,
                      input logic [3:0] a, input logic [15:0] d,
                      input bit es, input bit ei, input string tag);
    tick_i    = tk;
    cal_i     = cv;
    wr_en_i   = we;
    wr_addr_i = a;
    wr_data_i = d;
    @(posedge clk);
    q_sts.push_back(es);
    q_irq.push_back(ei);
    q_tag.push_back(tag);
    @(negedge clk);
    tick_i  = 1'b0;
    wr_en_i = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en_i   = 1'b1;
    wr_addr_i = a;
    wr_data_i = d;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [41:0] hit;
    n_tests = 0; n_fail = 0; done = 0;
    rst_n = 1'b0; tick_i = 1'b0; cal_i = '0;
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    hit = pack_cal(7'h45, 7'h30, 6'h12, 3'h3, 6'h21, 5'h06, 8'h55);

    // R1: reset state, and a tick on an all-zero calendar sets nothing
    step(1'b0, '0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R1 reset state");
    step(1'b1, '0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R1 tick after reset");

    // stage alarm, weekday excluded with a differing value (R2 layout)
    wr(4'd0, 16'h8045);
    wr(4'd1, 16'h8030);
    wr(4'd2, 16'h8012);
    wr(4'd3, 16'h0005);
    wr(4'd4, 16'h8021);
    wr(4'd5, 16'h8006);
    wr(4'd6, 16'h8055);

    // R3: staged only, no effect
    step(1'b1, hit, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R3 staged not active");
    step(1'b0, hit, 1'b1, 4'd7, 16'h0001, 1'b0, 1'b0, "R3 commit without bit15");
    step(1'b1, hit, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R3 still not active");
    wr(4'd7, 16'h8000);

    // R10 / R2: one field off
    step(1'b1, pack_cal(7'h46, 7'h30, 6'h12, 3'h3, 6'h21, 5'h06, 8'h55),
         1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R10 seconds differ");
    step(1'b1, pack_cal(7'h45, 7'h30, 6'h12, 3'h3, 6'h21, 5'h06, 8'h56),
         1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R2 year differs");
    // R5: equal but no tick
    step(1'b0, hit, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R5 equal without tick");

    // R4 / R7: match with weekday ignored, irq masked
    step(1'b1, hit, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0, "R4 match weekday ignored");
    step(1'b0, hit, 1'b1, 4'd8, 16'h0001, 1'b1, 1'b1, "R7 enable drives irq");
    // R8
    step(1'b0, hit, 1'b1, 4'd9, 16'h0000, 1'b1, 1'b1, "R8 write zero keeps status");
    step(1'b0, hit, 1'b1, 4'd9, 16'h0001, 1'b0, 1'b0, "R8 write one clears");
    // R5: calendar held equal, no re-fire
    step(1'b0, hit, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R5 no refire held 1");
    step(1'b0, hit, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R5 no refire held 2");

    // R9: set and clear together
    step(1'b1, hit, 1'b1, 4'd9, 16'h0001, 1'b1, 1'b1, "R9 set beats clear");
    step(1'b0, hit, 1'b1, 4'd9, 16'h0001, 1'b0, 1'b0, "R9 later clear works");

    // R7: status latches with enable off
    wr(4'd8, 16'h0000);
    step(1'b1, hit, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0, "R7 latch while disabled");
    wr(4'd9, 16'h0001);

    // R4 / R10: weekday now participates
    wr(4'd3, 16'h8005);
    wr(4'd7, 16'h8000);
    step(1'b1, hit, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R10 weekday differs");
    step(1'b1, pack_cal(7'h45, 7'h30, 6'h12, 3'h5, 6'h21, 5'h06, 8'h55),
         1'b0, 4'd0, 16'h0, 1'b1, 1'b0, "R4 weekday match");
    wr(4'd9, 16'h0001);

    // R6: no field participates
    for (int i = 0; i < 7; i++) wr(4'(i), 16'h0000);
    wr(4'd7, 16'h8000);
    step(1'b1, '0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R6 all fields off zero cal");
    step(1'b1, hit, 1'b0, 4'd0, 16'h0, 1'b0, 1'b0, "R6 all fields off");

    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule